// File: doc/BRIEF.md
# BPSK Byte Frame Modulator

This block takes bytes one at a time through a valid/ready handshake and turns each into a framed, sampled binary phase-shift-keyed waveform for an external DAC. A frame opens with a single full-scale sync sample, so a receiver can realign on every byte. After the sync sample come nine modulated bits: an even-parity bit first, then the eight data bits, most significant first.

Each modulated bit is a run of samples taken in order from a small signed waveform table supplied on an input port. A one sends the table values as they are and a zero sends them negated. A fixed mid-scale offset is added to every signed sample, so the DAC code is always unsigned. Mid-scale is also the channel's zero level, and the output rests there between frames. A free-running tick divider sets the sample rate: one new sample is emitted per tick, and the tick period is a parameter.

Top module: `bpsk_frame_mod`

## Requirements
- R1: A byte is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the next cycle on.
- R2: `in_ready` stays low through the whole frame. It returns high on the tick after the last data sample, in the same cycle that `dac_code` returns to the mid-scale code.
- R3: While `in_ready` is high, `dac_code` equals the mid-scale code 128. An `in_valid` offered while `in_ready` is low is ignored and does not change the frame in progress.
- R4: The first sample of a frame is the sync code 255, which is all ones.
- R5: Samples 2 to 9 of a frame carry the parity bit. The parity bit is the XOR of the eight data bits, so the ones across parity and data total an even number.
- R6: Samples 10 to 73 carry the data bits, most significant bit first, eight samples per bit.
- R7: Sample k (k = 0..7) of a bit reads signed table entry `wave_tbl[8k+7:8k]`. A one outputs 128 + entry and a zero outputs 128 - entry.
- R8: The output changes only on a tick. `sample_stb` is a one-cycle pulse every `TICK_DIV` clock cycles, and it is high in exactly the cycles in which a newly loaded `dac_code` is first visible.
- R9: After reset, `in_ready` is 1, `dac_code` is 128 and `sample_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | DATA_W | Byte to send |
| wave_tbl | input | SPB*SAMP_W | Signed waveform table, entry k at bits [SAMP_W*k +: SAMP_W] |
| dac_code | output | SAMP_W | Unsigned DAC sample code |
| sample_stb | output | 1 | Pulses when a new sample is loaded |

## Verification
The hardest case to reach from the ports is a byte offered while a frame is running. It must neither be taken when `in_ready` rises nor change the remaining samples. The stimulus raises `in_valid` with different data part-way through some frames and drops it before the frame drains. It then confirms that every remaining sample follows the original byte and that no second frame starts. Random bytes and random tables whose entries stay within ±100 are mixed with directed bytes: 0x00, 0xFF, a single low one and a single high one, so that both parity values occur. Directed tables hold all-zero and full-swing entries.

// File: rtl/bpsk_mod_pkg.sv
package bpsk_mod_pkg;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_ARMED,
        FS_BITS,
        FS_DRAIN
    } frame_state_e;

    typedef enum logic [1:0] {
        OK_ZERO,
        OK_SYNC,
        OK_WAVE
    } out_kind_e;

    localparam int SLOT_W = 8;

    typedef struct packed {
        out_kind_e         kind;
        logic              bit_val;
        logic [SLOT_W-1:0] slot;
    } sample_req_t;

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic even_parity_bit(input logic [63:0] v);
        return ^v;
    endfunction

endpackage

// File: rtl/bpsk_tick_gen.sv
module bpsk_tick_gen
    import bpsk_mod_pkg::*;
#(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = cnt_width(DIV);

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bpsk_frame_seq.sv
module bpsk_frame_seq
    import bpsk_mod_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SPB    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output sample_req_t       req
);
    localparam int NBITS = DATA_W + 1;
    localparam int BW    = cnt_width(NBITS);
    localparam int SW    = cnt_width(SPB);

    frame_state_e     st;
    logic [NBITS-1:0] shreg;
    logic [BW-1:0]    bit_cnt;
    logic [SW-1:0]    samp_cnt;
    logic             accept;
    logic             last_samp;
    logic             last_bit;

    assign in_ready  = (st == FS_IDLE);
    assign accept    = in_valid && in_ready;
    assign last_samp = (samp_cnt == SW'(SPB - 1));
    assign last_bit  = (bit_cnt == BW'(NBITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= FS_IDLE;
            shreg    <= '0;
            bit_cnt  <= '0;
            samp_cnt <= '0;
        end else begin
            case (st)
                FS_IDLE: begin
                    if (accept) begin
                        shreg <= {even_parity_bit(64'(in_data)), in_data};
                        st    <= FS_ARMED;
                    end
                end
                FS_ARMED: begin
                    if (tick) begin
                        bit_cnt  <= '0;
                        samp_cnt <= '0;
                        st       <= FS_BITS;
                    end
                end
                FS_BITS: begin
                    if (tick) begin
                        if (last_samp) begin
                            samp_cnt <= '0;
                            shreg    <= shreg << 1;
                            bit_cnt  <= bit_cnt + 1'b1;
                            if (last_bit) begin
                                st <= FS_DRAIN;
                            end
                        end else begin
                            samp_cnt <= samp_cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        st <= FS_IDLE;
                    end
                end
            endcase
        end
    end

    always_comb begin
        req.kind    = OK_ZERO;
        req.bit_val = 1'b0;
        req.slot    = '0;
        case (st)
            FS_ARMED: req.kind = OK_SYNC;
            FS_BITS: begin
                req.kind    = OK_WAVE;
                req.bit_val = shreg[NBITS-1];
                req.slot    = SLOT_W'(samp_cnt);
            end
            default: req.kind = OK_ZERO;
        endcase
    end
endmodule

// File: rtl/bpsk_sample_map.sv
module bpsk_sample_map
    import bpsk_mod_pkg::*;
#(
    parameter int SAMP_W = 8,
    parameter int SPB    = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  sample_req_t           req,
    input  logic [SPB*SAMP_W-1:0] wave_tbl,
    output logic [SAMP_W-1:0]     dac_code,
    output logic                  sample_stb
);
    localparam int                SW        = cnt_width(SPB);
    localparam int                AW        = SAMP_W + 2;
    localparam logic [SAMP_W-1:0] ZERO_CODE = {1'b1, {(SAMP_W-1){1'b0}}};
    localparam logic [SAMP_W-1:0] SYNC_CODE = '1;

    logic signed [SAMP_W-1:0] tbl [SPB];
    logic [SW-1:0]            idx;
    logic signed [AW-1:0]     tap;
    logic signed [AW-1:0]     level;
    logic [AW-1:0]            sum;
    logic [SAMP_W-1:0]        next_code;

    for (genvar g = 0; g < SPB; g++) begin : g_unpack
        assign tbl[g] = wave_tbl[g*SAMP_W +: SAMP_W];
    end

    assign idx   = req.slot[SW-1:0];
    assign tap   = AW'(tbl[idx]);
    assign level = req.bit_val ? tap : -tap;
    assign sum   = {2'b00, ZERO_CODE} + level;

    always_comb begin
        case (req.kind)
            OK_SYNC: next_code = SYNC_CODE;
            OK_WAVE: next_code = sum[SAMP_W-1:0];
            default: next_code = ZERO_CODE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_code   <= ZERO_CODE;
            sample_stb <= 1'b0;
        end else begin
            sample_stb <= tick;
            if (tick) begin
                dac_code <= next_code;
            end
        end
    end
endmodule

// File: rtl/bpsk_frame_mod.sv
module bpsk_frame_mod
    import bpsk_mod_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SPB      = 8,
    parameter int SAMP_W   = 8,
    parameter int TICK_DIV = 1000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [DATA_W-1:0]     in_data,
    input  logic [SPB*SAMP_W-1:0] wave_tbl,
    output logic [SAMP_W-1:0]     dac_code,
    output logic                  sample_stb
);
    logic        tick;
    sample_req_t req;

    bpsk_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    bpsk_frame_seq #(.DATA_W(DATA_W), .SPB(SPB)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .req      (req)
    );

    bpsk_sample_map #(.SAMP_W(SAMP_W), .SPB(SPB)) u_map (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .req        (req),
        .wave_tbl   (wave_tbl),
        .dac_code   (dac_code),
        .sample_stb (sample_stb)
    );
endmodule

// File: rtl/bpsk_frame_mod_chk.sv
module bpsk_frame_mod_chk #(
    parameter int SAMP_W   = 8,
    parameter int TICK_DIV = 1000
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [SAMP_W-1:0] dac_code,
    input logic              sample_stb
);
    localparam logic [SAMP_W-1:0] ZERO_CODE = {1'b1, {(SAMP_W-1){1'b0}}};
    localparam logic [SAMP_W-1:0] SYNC_CODE = '1;

    p_accept_drop_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> !in_ready);

    p_ready_rise_zero_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ready) |-> sample_stb && dac_code == ZERO_CODE);

    p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> dac_code == ZERO_CODE);

    p_sync_busy_r4: assert property (@(posedge clk) disable iff (rst)
        sample_stb && dac_code == SYNC_CODE |-> !in_ready);

    p_dac_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |-> $stable(dac_code));

    if (TICK_DIV > 1) begin : g_single
        p_strobe_single_r8: assert property (@(posedge clk) disable iff (rst)
            sample_stb |=> !sample_stb);
    end
endmodule

bind bpsk_frame_mod bpsk_frame_mod_chk #(
    .SAMP_W   (SAMP_W),
    .TICK_DIV (TICK_DIV)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .dac_code   (dac_code),
    .sample_stb (sample_stb)
);

// File: tb/bpsk_frame_mod_test.sv
`timescale 1ns/1ps
module bpsk_frame_mod_test;
    localparam int TICK = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic [63:0] wave_tbl = '0;
    logic [7:0]  dac_code;
    logic        sample_stb;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bpsk_frame_mod #(.TICK_DIV(TICK)) uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .wave_tbl   (wave_tbl),
        .dac_code   (dac_code),
        .sample_stb (sample_stb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // n = 0 sync, n = 1..72 modulated samples (parity bit, then data MSB first)
    function automatic int exp_code(input logic [7:0] d, input logic [63:0] t, input int n);
        logic [8:0] bits;
        int b, k, tv, v;
        if (n == 0) return 255;
        bits = {^d, d};
        b = (n - 1) / 8;
        k = (n - 1) % 8;
        tv = int'($signed(t[k*8 +: 8]));
        v = 128 + (bits[8-b] ? tv : -tv);
        return v & 255;
    endfunction

    function automatic logic [63:0] rand_tbl();
        logic [63:0] t;
        for (int i = 0; i < 8; i++) begin
            int e;
            e = int'($urandom_range(200)) - 100;
            t[i*8 +: 8] = e[7:0];
        end
        return t;
    endfunction

    task automatic run_frame(input logic [7:0] d, input logic [63:0] t, input bit poke);
        int n = 0;
        int cyc = 0;
        int last = -1;
        int per_bad = 0;
        int rdy_bad = 0;
        int got_poke = 0;
        wave_tbl = t;
        @(negedge clk);
        chk(in_ready == 1'b1, "R3 ready idle", int'(in_ready), 1);
        chk(dac_code == 8'd128, "R3 idle level", int'(dac_code), 128);
        in_data  = d;
        in_valid = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b0, "R1 ready drop", int'(in_ready), 0);
        in_valid = 1'b0;
        in_data  = 8'($urandom);
        while (n < 73) begin
            @(negedge clk);
            cyc++;
            if (in_ready) rdy_bad++;
            if (poke && n == 20 && !got_poke) begin
                in_valid = 1'b1;   // R3: byte offered while busy
                in_data  = ~d;
                got_poke = 1;
            end
            if (poke && n == 30) in_valid = 1'b0;
            if (sample_stb) begin
                if (n == 0)
                    chk(dac_code == 8'(exp_code(d, t, n)), "R4 sync", int'(dac_code), exp_code(d, t, n));
                else if (n <= 8)
                    chk(dac_code == 8'(exp_code(d, t, n)), "R5 parity", int'(dac_code), exp_code(d, t, n));
                else
                    chk(dac_code == 8'(exp_code(d, t, n)), "R6/R7 data", int'(dac_code), exp_code(d, t, n));
                if (last >= 0 && cyc - last != TICK) per_bad++;
                last = cyc;
                n++;
            end
        end
        in_valid = 1'b0;
        do begin
            @(negedge clk);
            cyc++;
            if (!sample_stb && in_ready) rdy_bad++;
        end while (!sample_stb);
        if (cyc - last != TICK) per_bad++;
        chk(rdy_bad == 0, "R2 busy ready", rdy_bad, 0);
        chk(in_ready == 1'b1, "R2 ready return", int'(in_ready), 1);
        chk(dac_code == 8'd128, "R2 return level", int'(dac_code), 128);
        chk(per_bad == 0, "R8 tick period", per_bad, 0);
        if (poke) begin
            repeat (2 * TICK) @(negedge clk);
            chk(in_ready == 1'b1, "R3 busy byte dropped", int'(in_ready), 1);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        chk(in_ready == 1'b1, "R9 ready", int'(in_ready), 1);
        chk(dac_code == 8'd128, "R9 dac", int'(dac_code), 128);
        chk(sample_stb == 1'b0, "R9 strobe", int'(sample_stb), 0);

        run_frame(8'h00, 64'h64646464_64646464, 0);
        run_frame(8'hFF, 64'h9C9C9C9C_9C9C9C9C, 0);
        run_frame(8'h01, 64'h00000000_00000000, 0);
        run_frame(8'h80, 64'h9C64_0A_F6_32CE_647F - 64'h7F + 64'h64, 1);
        run_frame(8'hA5, rand_tbl(), 1);
        for (int i = 0; i < 20; i++) begin
            run_frame(8'($urandom), rand_tbl(), (i % 3) == 0);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule